// File: doc/BRIEF.md
# Hierarchical Interrupt Priority Encoder

The encoder collects interrupt requests from three tiers (critical, main and peripheral) and folds them into one 32-bit status word. For each tier the word holds a pending flag and the number of that tier's winning source. Two source slots are not wired to pins. They carry the peripheral tier upward instead. Critical source 2 is asserted when any unmasked peripheral flagged as high priority is pending. Main source 4 is asserted when any unmasked peripheral of normal priority is pending. Peripheral source 0 is driven by a single cascade line from a DMA engine.

Software writes masks, a per-source boost register for the main and peripheral tiers, and a master enable through a small word-addressed register port. It reads the status word through the same port. Dispatch software tests the critical flag first, then the main flag, then the peripheral flag. When the critical field shows 2 or the main field shows 4, it reads the peripheral field to find the actual source. The processor interrupt line follows the status word and the master enable combinationally.

Top module: `irq_hier_enc`

## Requirements
- R1: After reset the registers read as follows. Address 0 (control) reads 0. Address 1 (main mask) reads 0x00010FFF. Address 2 (peripheral mask) reads 0x7FFFFC00. Address 3 (main boost) reads 0. Address 4 (peripheral boost) reads 0.
- R2: Address 5 returns the status word. Bit 10 is the critical pending flag and bits 9:8 hold the critical source number. Bit 21 is the main pending flag and bits 20:16 hold the main source number. Bit 29 is the peripheral pending flag and bits 28:24 hold the peripheral source number. All other bits read 0, and a field reads 0 when its flag is clear.
- R3: In the main mask, a 1 disables a source, and main source n is controlled by bit (16 - n). A write takes effect from the next clock.
- R4: In the peripheral mask, a 1 disables a source, and peripheral source n is controlled by bit (31 - n).
- R5: Within a tier, the lowest-numbered unmasked pending source wins when no boost bit applies.
- R6: Boost bit n at address 3 (main) or address 4 (peripheral) marks source n as high priority. Any pending unmasked boosted source beats every unboosted one, and the lowest-numbered source wins among the boosted.
- R7: Critical source 2 is pending exactly when an unmasked boosted peripheral is pending. The pin crit_req_i[2] has no effect.
- R8: Main source 4 is pending exactly when an unmasked unboosted peripheral is pending. The pin main_req_i[4] has no effect.
- R9: Peripheral source 0 is driven by dma_req_i. The pin per_req_i[0] has no effect.
- R10: irq_o is 1 exactly when the master enable (control bit 0) is set and at least one of the three pending flags is set.
- R11: Control bits 7:4 mask the critical sources: bit 4+n set disables critical source n.
- R12: Writes to address 5 have no effect. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| crit_req_i | input | 4 | Critical request lines (bit 2 unused) |
| main_req_i | input | MAIN_N | Main request lines (bit 4 unused) |
| per_req_i | input | PER_N | Peripheral request lines (bit 0 unused) |
| dma_req_i | input | 1 | DMA cascade request, peripheral source 0 |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The status path is combinational from the request pins and the register state. A wrong mask, boost or control bit therefore shows up in the status read and on irq_o in the first cycle that a request depends on it. A mask bit held at the wrong position, or a cascade decision taken from the wrong boost sense, appears as a wrong source number or as a flag missing from a tier that should mirror the peripheral tier. The bench compares the read data and irq_o against a behavioural model in every cycle. This catches a corrupted register one cycle after the write that should have set it.

// File: rtl/irq_enc_pkg.sv
`timescale 1ns/1ps
package irq_enc_pkg;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int CRIT_N = 4;

  // reserved cascade slots
  localparam int HPP_SRC = 2;   // critical tier: boosted peripheral
  localparam int LPP_SRC = 4;   // main tier: normal peripheral
  localparam int DMA_SRC = 0;   // peripheral tier: dma line

  // status word layout
  localparam int ST_CRIT_FLAG = 10;
  localparam int ST_CRIT_LSB  = 8;
  localparam int ST_MAIN_FLAG = 21;
  localparam int ST_MAIN_LSB  = 16;
  localparam int ST_PER_FLAG  = 29;
  localparam int ST_PER_LSB   = 24;

  typedef enum logic [AW-1:0] {
    A_CTRL  = 3'd0,
    A_MMASK = 3'd1,
    A_PMASK = 3'd2,
    A_MBST  = 3'd3,
    A_PBST  = 3'd4,
    A_STAT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_tier_pick.sv
`timescale 1ns/1ps
module irq_tier_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  act_i,
  input  logic [N-1:0]  boost_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] hi_w, cand_w;

  always_comb begin
    hi_w   = act_i & boost_i;
    cand_w = (|hi_w) ? hi_w : act_i;
    idx_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_w[i]) idx_o = IW'(i);
    end
    any_o = |act_i;
  end
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
  import irq_enc_pkg::*;
#(
  parameter int          MAIN_N   = 17,
  parameter int          PER_N    = 32,
  parameter logic [31:0] MMASK_RV = 32'h0001_0FFF,
  parameter logic [31:0] PMASK_RV = 32'h7FFF_FC00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     status_i,
  output logic [DW-1:0]     rdata_o,
  output logic              me_o,
  output logic [CRIT_N-1:0] crit_mask_o,
  output logic [MAIN_N-1:0] main_mask_o,
  output logic [PER_N-1:0]  per_mask_o,
  output logic [MAIN_N-1:0] main_boost_o,
  output logic [PER_N-1:0]  per_boost_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      me_o         <= 1'b0;
      crit_mask_o  <= '0;
      main_mask_o  <= MMASK_RV[MAIN_N-1:0];
      per_mask_o   <= PMASK_RV[PER_N-1:0];
      main_boost_o <= '0;
      per_boost_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: begin
          me_o        <= wdata_i[0];
          crit_mask_o <= wdata_i[4 +: CRIT_N];
        end
        A_MMASK: main_mask_o  <= wdata_i[MAIN_N-1:0];
        A_PMASK: per_mask_o   <= wdata_i[PER_N-1:0];
        A_MBST:  main_boost_o <= wdata_i[MAIN_N-1:0];
        A_PBST:  per_boost_o  <= wdata_i[PER_N-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[0]          = me_o;
        rdata_o[4 +: CRIT_N] = crit_mask_o;
      end
      A_MMASK: rdata_o[MAIN_N-1:0] = main_mask_o;
      A_PMASK: rdata_o[PER_N-1:0]  = per_mask_o;
      A_MBST:  rdata_o[MAIN_N-1:0] = main_boost_o;
      A_PBST:  rdata_o[PER_N-1:0]  = per_boost_o;
      A_STAT:  rdata_o             = status_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_hier_enc.sv
`timescale 1ns/1ps
module irq_hier_enc
  import irq_enc_pkg::*;
#(
  parameter int          MAIN_N   = 17,
  parameter int          PER_N    = 32,
  parameter logic [31:0] MMASK_RV = 32'h0001_0FFF,
  parameter logic [31:0] PMASK_RV = 32'h7FFF_FC00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [CRIT_N-1:0] crit_req_i,
  input  logic [MAIN_N-1:0] main_req_i,
  input  logic [PER_N-1:0]  per_req_i,
  input  logic              dma_req_i,
  output logic              irq_o
);
  localparam int MIW = $clog2(MAIN_N);
  localparam int PIW = $clog2(PER_N);
  localparam int CIW = $clog2(CRIT_N);

  logic              me_w;
  logic [CRIT_N-1:0] crit_mask_w;
  logic [MAIN_N-1:0] main_mask_w, main_boost_w, main_src_w, main_act_w;
  logic [PER_N-1:0]  per_mask_w, per_boost_w, per_src_w, per_act_w;
  logic [CRIT_N-1:0] crit_src_w, crit_act_w;
  logic              hp_any_w, lp_any_w;
  logic              crit_any_w, main_any_w, per_any_w;
  logic [CIW-1:0]    crit_idx_w;
  logic [MIW-1:0]    main_idx_w;
  logic [PIW-1:0]    per_idx_w;
  logic [DW-1:0]     status_w;
  logic              unused_pins;

  assign unused_pins = ^{crit_req_i[HPP_SRC], main_req_i[LPP_SRC], per_req_i[DMA_SRC]};

  irq_regs #(
    .MAIN_N(MAIN_N), .PER_N(PER_N), .MMASK_RV(MMASK_RV), .PMASK_RV(PMASK_RV)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .status_i(status_w), .rdata_o(rdata_o),
    .me_o(me_w), .crit_mask_o(crit_mask_w), .main_mask_o(main_mask_w),
    .per_mask_o(per_mask_w), .main_boost_o(main_boost_w), .per_boost_o(per_boost_w)
  );

  // mask bits are stored mirrored: source n at bit (N-1-n)
  for (genvar n = 0; n < PER_N; n++) begin : g_per
    if (n == DMA_SRC) begin : g_dma
      assign per_src_w[n] = dma_req_i;
    end else begin : g_pin
      assign per_src_w[n] = per_req_i[n];
    end
    assign per_act_w[n] = per_src_w[n] & ~per_mask_w[PER_N-1-n];
  end

  assign hp_any_w = |(per_act_w & per_boost_w);
  assign lp_any_w = |(per_act_w & ~per_boost_w);

  for (genvar n = 0; n < MAIN_N; n++) begin : g_main
    if (n == LPP_SRC) begin : g_casc
      assign main_src_w[n] = lp_any_w;
    end else begin : g_pin
      assign main_src_w[n] = main_req_i[n];
    end
    assign main_act_w[n] = main_src_w[n] & ~main_mask_w[MAIN_N-1-n];
  end

  for (genvar n = 0; n < CRIT_N; n++) begin : g_crit
    if (n == HPP_SRC) begin : g_casc
      assign crit_src_w[n] = hp_any_w;
    end else begin : g_pin
      assign crit_src_w[n] = crit_req_i[n];
    end
    assign crit_act_w[n] = crit_src_w[n] & ~crit_mask_w[n];
  end

  irq_tier_pick #(.N(CRIT_N), .IW(CIW)) u_crit (
    .act_i(crit_act_w), .boost_i('0), .any_o(crit_any_w), .idx_o(crit_idx_w));
  irq_tier_pick #(.N(MAIN_N), .IW(MIW)) u_main (
    .act_i(main_act_w), .boost_i(main_boost_w), .any_o(main_any_w), .idx_o(main_idx_w));
  irq_tier_pick #(.N(PER_N), .IW(PIW)) u_per (
    .act_i(per_act_w), .boost_i(per_boost_w), .any_o(per_any_w), .idx_o(per_idx_w));

  always_comb begin
    status_w = '0;
    status_w[ST_CRIT_FLAG]        = crit_any_w;
    status_w[ST_CRIT_LSB +: 2]    = 2'(crit_idx_w);
    status_w[ST_MAIN_FLAG]        = main_any_w;
    status_w[ST_MAIN_LSB +: 5]    = 5'(main_idx_w);
    status_w[ST_PER_FLAG]         = per_any_w;
    status_w[ST_PER_LSB +: 5]     = 5'(per_idx_w);
  end

  assign irq_o = me_w & (crit_any_w | main_any_w | per_any_w);
endmodule

// File: rtl/irq_hier_enc_chk.sv
`timescale 1ns/1ps
module irq_hier_enc_chk #(
  parameter int MAIN_N = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input logic [31:0]       status_i,
  input logic              me_i,
  input logic [MAIN_N-1:0] main_mask_i
);
  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (me_i && (status_i[10] || status_i[21] || status_i[29])));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i & ~32'h3F3F_0700) == 32'h0);

  // R2
  main_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_i[21] |-> status_i[20:16] == 5'd0);

  // R8
  lpp_casc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[21] && status_i[20:16] == 5'd4) |-> status_i[29]);

  // R7
  hpp_casc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[10] && status_i[9:8] == 2'd2) |-> status_i[29]);

  // R3
  mmask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd1) |=> main_mask_i == $past(wdata_i[MAIN_N-1:0]));
endmodule

bind irq_hier_enc irq_hier_enc_chk #(.MAIN_N(MAIN_N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .status_i(status_w), .me_i(me_w),
  .main_mask_i(main_mask_w)
);

// File: tb/sim_irq_hier_enc.sv
`timescale 1ns/1ps
module sim_irq_hier_enc;
  localparam int MN = 17;
  localparam int PN = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [3:0]    crit = '0;
  logic [MN-1:0] mreq = '0;
  logic [PN-1:0] preq = '0;
  logic          dma = 1'b0;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  logic          m_me;
  logic [3:0]    m_cmask;
  logic [MN-1:0] m_mmask, m_mbst;
  logic [PN-1:0] m_pmask, m_pbst;

  always #5 clk = ~clk;

  irq_hier_enc u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .crit_req_i(crit), .main_req_i(mreq), .per_req_i(preq),
    .dma_req_i(dma), .irq_o(irq)
  );

  function automatic logic [31:0] model_status();
    logic [31:0] s;
    bit hp, lp, pa, ma, ca, act;
    int pw, pwb, mw, mwb, cw;
    s = 0; hp = 0; lp = 0; pa = 0; ma = 0; ca = 0;
    pw = -1; pwb = -1; mw = -1; mwb = -1; cw = -1;
    for (int n = 0; n < PN; n++) begin
      act = ((n == 0) ? dma : preq[n]) && !m_pmask[PN-1-n];
      if (act) begin
        pa = 1;
        if (m_pbst[n]) begin hp = 1; if (pwb < 0) pwb = n; end
        else lp = 1;
        if (pw < 0) pw = n;
      end
    end
    for (int n = 0; n < MN; n++) begin
      act = ((n == 4) ? lp : mreq[n]) && !m_mmask[MN-1-n];
      if (act) begin
        ma = 1;
        if (m_mbst[n] && mwb < 0) mwb = n;
        if (mw < 0) mw = n;
      end
    end
    for (int n = 0; n < 4; n++) begin
      act = ((n == 2) ? hp : crit[n]) && !m_cmask[n];
      if (act) begin ca = 1; if (cw < 0) cw = n; end
    end
    if (pwb >= 0) pw = pwb;
    if (mwb >= 0) mw = mwb;
    if (ca) begin s[10] = 1; s[9:8] = 2'(cw); end
    if (ma) begin s[21] = 1; s[20:16] = 5'(mw); end
    if (pa) begin s[29] = 1; s[28:24] = 5'(pw); end
    return s;
  endfunction

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    logic [31:0] r;
    r = 0;
    case (a)
      3'd0: begin r[0] = m_me; r[7:4] = m_cmask; end
      3'd1: r[MN-1:0] = m_mmask;
      3'd2: r = m_pmask;
      3'd3: r[MN-1:0] = m_mbst;
      3'd4: r = m_pbst;
      3'd5: r = model_status();
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic model_reset();
    m_me = 0; m_cmask = 0; m_mmask = 17'h10FFF; m_pmask = 32'h7FFFFC00;
    m_mbst = 0; m_pbst = 0;
  endtask

  task automatic step(input string tag, input logic w, input logic [2:0] a,
                      input logic [31:0] d, input logic [3:0] c,
                      input logic [MN-1:0] mr, input logic [PN-1:0] pr,
                      input logic dm);
    logic [31:0] exp_rd;
    logic exp_irq;
    @(negedge clk);
    we = w; addr = a; wdata = d; crit = c; mreq = mr; preq = pr; dma = dm;
    #1;
    exp_rd  = model_rd(a);
    exp_irq = m_me && (model_status() & 32'h2020_0400) != 0;
    n_cmp++;
    if (rdata !== exp_rd || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
               tag, a, rdata, irq, exp_rd, exp_irq);
    end
    @(posedge clk);
    #1;
    if (w) begin
      case (a)
        3'd0: begin m_me = d[0]; m_cmask = d[7:4]; end
        3'd1: m_mmask = d[MN-1:0];
        3'd2: m_pmask = d;
        3'd3: m_mbst = d[MN-1:0];
        3'd4: m_pbst = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [3:0] c,
                    input logic [MN-1:0] mr, input logic [PN-1:0] pr, input logic dm);
    step(tag, 1'b0, a, 32'h0, c, mr, pr, dm);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [31:0] d);
    step(tag, 1'b1, a, d, 4'h0, '0, '0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 5; a++) rd("R1", 3'(a), 4'h0, '0, '0, 1'b0);
    // R12 unmapped reads zero
    rd("R12", 3'd6, 4'h0, '0, '0, 1'b0);
    rd("R12", 3'd7, 4'h0, '0, '0, 1'b0);
    // R9 dma feeds peripheral 0, R8 cascades into main 4, R10 irq off while disabled
    rd("R9", 3'd5, 4'h0, '0, '0, 1'b1);
    rd("R10", 3'd5, 4'h0, '0, '0, 1'b1);
    // R9 per_req_i[0] ignored
    rd("R9", 3'd5, 4'h0, '0, 32'h1, 1'b0);
    wr("R10", 3'd0, 32'h1);
    rd("R10", 3'd5, 4'h0, '0, '0, 1'b1);
    rd("R10", 3'd5, 4'h0, '0, '0, 1'b0);
    // R4 masked peripheral 5 ignored, unmasked 22 wins
    rd("R4", 3'd5, 4'h0, '0, (32'h1 << 5), 1'b0);
    rd("R4", 3'd5, 4'h0, '0, (32'h1 << 22) | (32'h1 << 5), 1'b0);
    // R5 lowest unmasked main wins
    rd("R5", 3'd5, 4'h0, 17'h6, '0, 1'b0);
    // R3 mask main source 1 at bit 15
    wr("R3", 3'd1, 32'h0001_8FFF);
    rd("R3", 3'd1, 4'h0, '0, '0, 1'b0);
    rd("R3", 3'd5, 4'h0, 17'h6, '0, 1'b0);
    wr("R3", 3'd1, 32'h0);
    // R6 boosted main 3 beats main 1
    wr("R6", 3'd3, 32'h8);
    rd("R6", 3'd5, 4'h0, 17'ha, '0, 1'b0);
    // R6/R7 boosted peripheral 25 routes to critical 2 and beats 23
    wr("R6", 3'd2, 32'h0);
    wr("R7", 3'd4, 32'h1 << 25);
    rd("R6", 3'd5, 4'h0, '0, (32'h1 << 25) | (32'h1 << 23), 1'b0);
    rd("R7", 3'd5, 4'h0, '0, (32'h1 << 25), 1'b0);
    // R7 crit_req_i[2] ignored
    rd("R7", 3'd5, 4'h4, '0, '0, 1'b0);
    // R8 main_req_i[4] ignored
    rd("R8", 3'd5, 4'h0, 17'h10, '0, 1'b0);
    // R11 mask critical 0, critical 3 reported
    rd("R11", 3'd5, 4'h9, '0, '0, 1'b0);
    wr("R11", 3'd0, 32'h11);
    rd("R11", 3'd5, 4'h9, '0, '0, 1'b0);
    rd("R11", 3'd0, 4'h0, '0, '0, 1'b0);
    // R12 status write ignored
    wr("R12", 3'd5, 32'hFFFF_FFFF);
    rd("R12", 3'd5, 4'h0, 17'h2, '0, 1'b0);

    // R2 random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [2:0] a;
      w = ($urandom_range(0, 7) == 0);
      a = 3'($urandom_range(0, 7));
      step("R2", w, a, $urandom(), 4'($urandom()), MN'($urandom()),
           $urandom() & $urandom(), 1'($urandom()));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule